// File: doc/BRIEF.md
# Vectored Interrupt Priority Resolver

This block decides which exception the processor core services next and gives the address of that source's vector. It looks at the non-maskable request line, the active-low level-sensitive external request line, and twelve timer and counter sources, each given as a flag with its own enable bit. It also takes a serial-peripheral request formed from a flag, a fault flag and one enable, and a serial-communications request that a small sub-resolver builds from receive, transmit and idle status bits. Two global mask bits from the condition-code register gate these sources. Two strobes from the instruction decoder select the trap vectors for an undefined opcode and for a software interrupt.

The core pulses a boundary strobe once per instruction boundary. On that cycle the resolver registers the chosen vector and a valid bit. Both then stay unchanged until the next strobe, so the address is stable while registers are stacked. A separate combinational wake output tells a waiting core that an unmasked request is pending. It uses exactly the gating of the selection path.

Maskable vectors descend in steps of two bytes from 0xFFF2, in priority order. If nothing is pending, the vector register holds 0xFFF2 and the valid bit is low.

Top module: `irq_vector_resolver`

## Requirements
- R1: While `rst_n` is low at a clock edge, `vec_addr` becomes 0xFFF2 and `vec_valid` becomes 0.
- R2: `vec_addr` and `vec_valid` load only at a rising edge where `boundary_stb` is 1. The new value is visible after that edge. With `boundary_stb` at 0 they hold their value.
- R3: A non-maskable request exists when `nmi_n` is 0 and `mask_x` is 0. It selects 0xFFF4, outranks every maskable source and both traps, and is ignored while `mask_x` is 1. It does not depend on `mask_i`.
- R4: With `mask_i` at 0, the maskable sources rank highest first as follows: `irq_n` low at 0xFFF2; `tmr_flag`/`tmr_en` bit 0 through bit 11 at 0xFFF0 down to 0xFFDA, where bit k maps to 0xFFF0 − 2k; SPI at 0xFFD8; SCI at 0xFFD6.
- R5: A timer source bit k is pending only when `tmr_flag[k]` and `tmr_en[k]` are both 1.
- R6: The SPI request is (`spi_flag` or `spi_fault`) and `spi_en`.
- R7: The SCI request is true when any one of these holds: (`sci_rx_full` or `sci_rx_overrun`) with `sci_rx_ie` and `sci_rx_on`; `sci_tx_empty` with `sci_tx_empty_ie` and `sci_tx_on`; `sci_tx_done` with `sci_tx_done_ie` and `sci_tx_on`; `sci_rx_idle` with `sci_idle_ie` and `sci_rx_on`.
- R8: While `mask_i` is 1, no maskable source is selected, the `irq_n` line included.
- R9: If no interrupt is pending, `trap_illegal` selects 0xFFF8 and `trap_swi` selects 0xFFF6, whatever the values of `mask_i` and `mask_x`. When both strobes are high, the illegal-opcode trap wins. A pending unmasked interrupt outranks both traps.
- R10: At a boundary with nothing selected, `vec_addr` becomes 0xFFF2 and `vec_valid` becomes 0. When any source is selected, `vec_valid` becomes 1.
- R11: `wake` is 1 exactly when a non-maskable request exists or, with `mask_i` at 0, any maskable source is pending. Trap strobes do not affect it.
- R12: `irq_n` is level sensitive. While it is held low and nothing ranks above it, every boundary selects 0xFFF2 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boundary_stb | input | 1 | Instruction-boundary strobe; loads the vector register |
| mask_x | input | 1 | Non-maskable request mask bit |
| mask_i | input | 1 | Global mask bit for maskable sources |
| nmi_n | input | 1 | Non-maskable request, active low |
| irq_n | input | 1 | External level request, active low |
| trap_illegal | input | 1 | Decoder strobe for an undefined opcode |
| trap_swi | input | 1 | Decoder strobe for a software interrupt |
| tmr_flag | input | 12 | Timer/counter source flags, bit 0 highest priority |
| tmr_en | input | 12 | Matching enables for `tmr_flag` |
| spi_flag | input | 1 | SPI transfer-complete flag |
| spi_fault | input | 1 | SPI mode-fault flag |
| spi_en | input | 1 | SPI interrupt enable |
| sci_rx_full | input | 1 | SCI receive data full |
| sci_rx_overrun | input | 1 | SCI receive overrun |
| sci_tx_empty | input | 1 | SCI transmit data empty |
| sci_tx_done | input | 1 | SCI transmission complete |
| sci_rx_idle | input | 1 | SCI idle line detected |
| sci_rx_ie | input | 1 | SCI receive interrupt enable |
| sci_tx_empty_ie | input | 1 | SCI transmit-empty interrupt enable |
| sci_tx_done_ie | input | 1 | SCI transmit-complete interrupt enable |
| sci_idle_ie | input | 1 | SCI idle interrupt enable |
| sci_rx_on | input | 1 | SCI receiver enabled |
| sci_tx_on | input | 1 | SCI transmitter enabled |
| vec_addr | output | 16 | Registered vector address |
| vec_valid | output | 1 | Registered: a source was selected |
| wake | output | 1 | An unmasked request is pending |

## Verification
The hardest case to reach is the full fifteen-deep maskable ordering. Each rank must win only after every source above it has gone away, and it must be removed in a way that exercises the paired gating. The bench first makes all fifteen maskable sources pending at once. It then removes them one by one from the top, taking away an enable while leaving its flag set, so each boundary must expose the next vector down. The SCI sub-resolver is reached through each of its five qualifying terms in turn. Each term is also tried with its enable or its receiver/transmitter gate missing.

// File: rtl/irqv_pkg.sv
// Package: shared widths and vector constants for the interrupt resolver.
// Assumes a 16-bit vector space with two-byte vector slots.
package irqv_pkg;
    localparam int VEC_W = 16;
    localparam logic [VEC_W-1:0] VEC_ILLEGAL = 16'hFFF8;
    localparam logic [VEC_W-1:0] VEC_SWI     = 16'hFFF6;
    localparam logic [VEC_W-1:0] VEC_NMI     = 16'hFFF4;
    localparam logic [VEC_W-1:0] VEC_MASK_TOP = 16'hFFF2;
    localparam int SLOT_BYTES = 2;
endpackage

// File: rtl/irqv_sci_req.sv
// Module: irqv_sci_req
// Forms the single serial-communications request from its status flags,
// per-event enables and the receiver/transmitter enables. Pure combinational.
module irqv_sci_req (
    input  logic rx_full,
    input  logic rx_overrun,
    input  logic tx_empty,
    input  logic tx_done,
    input  logic rx_idle,
    input  logic rx_ie,
    input  logic tx_empty_ie,
    input  logic tx_done_ie,
    input  logic idle_ie,
    input  logic rx_on,
    input  logic tx_on,
    output logic req
);
    logic rx_term, tx_term;

    // Combine receive-side and transmit-side qualified events.
    always_comb begin
        rx_term = rx_on & (((rx_full | rx_overrun) & rx_ie) | (rx_idle & idle_ie));
        tx_term = tx_on & ((tx_empty & tx_empty_ie) | (tx_done & tx_done_ie));
        req     = rx_term | tx_term;
    end
endmodule

// File: rtl/irqv_prio_enc.sv
// Module: irqv_prio_enc
// Fixed-priority encoder: reports whether any request is set and the index of
// the lowest-numbered set bit (index 0 is the highest priority).
module irqv_prio_enc #(
    parameter int N = 15,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Walk from lowest priority upward so the highest-priority hit is kept.
    always_comb begin
        any = |req;
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) idx = IDX_W'(k);
        end
    end
endmodule

// File: rtl/irq_vector_resolver.sv
// Module: irq_vector_resolver (top)
// Selects the vector of the highest-priority request: non-maskable request,
// then the maskable sources in fixed order, then the decoder traps. Registers
// the result at each instruction-boundary strobe. Assumes flags and enables
// are synchronous to clk and that trap strobes are valid with boundary_stb.
module irq_vector_resolver
    import irqv_pkg::*;
#(
    parameter int N_TMR = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary_stb,
    input  logic             mask_x,
    input  logic             mask_i,
    input  logic             nmi_n,
    input  logic             irq_n,
    input  logic             trap_illegal,
    input  logic             trap_swi,
    input  logic [N_TMR-1:0] tmr_flag,
    input  logic [N_TMR-1:0] tmr_en,
    input  logic             spi_flag,
    input  logic             spi_fault,
    input  logic             spi_en,
    input  logic             sci_rx_full,
    input  logic             sci_rx_overrun,
    input  logic             sci_tx_empty,
    input  logic             sci_tx_done,
    input  logic             sci_rx_idle,
    input  logic             sci_rx_ie,
    input  logic             sci_tx_empty_ie,
    input  logic             sci_tx_done_ie,
    input  logic             sci_idle_ie,
    input  logic             sci_rx_on,
    input  logic             sci_tx_on,
    output logic [VEC_W-1:0] vec_addr,
    output logic             vec_valid,
    output logic             wake
);
    localparam int N_MASK = N_TMR + 3;
    localparam int IDX_W  = $clog2(N_MASK);

    logic              sci_req, spi_req, nmi_req;
    logic [N_MASK-1:0] mask_req, mask_gated;
    logic              mask_any;
    logic [IDX_W-1:0]  mask_idx;
    logic [VEC_W-1:0]  nxt_addr;
    logic              nxt_valid;

    irqv_sci_req u_sci (
        .rx_full     (sci_rx_full),
        .rx_overrun  (sci_rx_overrun),
        .tx_empty    (sci_tx_empty),
        .tx_done     (sci_tx_done),
        .rx_idle     (sci_rx_idle),
        .rx_ie       (sci_rx_ie),
        .tx_empty_ie (sci_tx_empty_ie),
        .tx_done_ie  (sci_tx_done_ie),
        .idle_ie     (sci_idle_ie),
        .rx_on       (sci_rx_on),
        .tx_on       (sci_tx_on),
        .req         (sci_req)
    );

    // Assemble maskable requests in priority order and apply the global mask.
    always_comb begin
        spi_req    = (spi_flag | spi_fault) & spi_en;
        nmi_req    = ~nmi_n & ~mask_x;
        mask_req   = {sci_req, spi_req, tmr_flag & tmr_en, ~irq_n};
        mask_gated = mask_i ? '0 : mask_req;
    end

    irqv_prio_enc #(.N(N_MASK)) u_enc (
        .req (mask_gated),
        .any (mask_any),
        .idx (mask_idx)
    );

    // Choose the next vector: non-maskable, maskable, illegal trap, software trap.
    always_comb begin
        nxt_valid = 1'b1;
        if (nmi_req)
            nxt_addr = VEC_NMI;
        else if (mask_any)
            nxt_addr = VEC_MASK_TOP - VEC_W'(SLOT_BYTES * int'(mask_idx));
        else if (trap_illegal)
            nxt_addr = VEC_ILLEGAL;
        else if (trap_swi)
            nxt_addr = VEC_SWI;
        else begin
            nxt_addr  = VEC_MASK_TOP;
            nxt_valid = 1'b0;
        end
    end

    // Wake whenever an unmasked interrupt is pending; same gating as selection.
    always_comb wake = nmi_req | mask_any;

    // Hold the chosen vector stable between instruction boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_addr  <= VEC_MASK_TOP;
            vec_valid <= 1'b0;
        end else if (boundary_stb) begin
            vec_addr  <= nxt_addr;
            vec_valid <= nxt_valid;
        end
    end
endmodule

// File: rtl/irqv_checker.sv
// Module: irqv_checker
// Temporal properties of the resolver, observed at its ports only.
module irqv_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        boundary_stb,
    input logic        mask_x,
    input logic        mask_i,
    input logic        nmi_n,
    input logic        trap_illegal,
    input logic        trap_swi,
    input logic [15:0] vec_addr,
    input logic        vec_valid,
    input logic        wake
);
    // R2: outputs only move at a boundary strobe.
    assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary_stb |=> $stable(vec_addr) && $stable(vec_valid));

    // R3: an unmasked non-maskable request wins the next boundary.
    assert_nmi_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        boundary_stb && !nmi_n && !mask_x |=> vec_addr == 16'hFFF4 && vec_valid);

    // R8: with both masks closed and no trap, nothing becomes valid.
    assert_mask_i_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        boundary_stb && mask_i && (nmi_n || mask_x) && !trap_illegal && !trap_swi
        |=> !vec_valid);

    // R9: an illegal-opcode strobe with nothing pending selects its trap.
    assert_illegal_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        boundary_stb && trap_illegal && !wake |=> vec_addr == 16'hFFF8 && vec_valid);

    // R10: an invalid result always carries the fallback vector.
    assert_fallback_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> vec_addr == 16'hFFF2);

    // R11: fully masked requests never wake the core.
    assert_no_wake_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mask_i && (nmi_n || mask_x) |-> !wake);
endmodule

bind irq_vector_resolver irqv_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .boundary_stb (boundary_stb),
    .mask_x       (mask_x),
    .mask_i       (mask_i),
    .nmi_n        (nmi_n),
    .trap_illegal (trap_illegal),
    .trap_swi     (trap_swi),
    .vec_addr     (vec_addr),
    .vec_valid    (vec_valid),
    .wake         (wake)
);

// File: tb/irq_vector_resolver_tb.sv
`timescale 1ns/1ps
module irq_vector_resolver_tb;
    logic clk = 1'b0;
    logic rst_n;
    logic boundary_stb, mask_x, mask_i, nmi_n, irq_n, trap_illegal, trap_swi;
    logic [11:0] tmr_flag, tmr_en;
    logic spi_flag, spi_fault, spi_en;
    logic sci_rx_full, sci_rx_overrun, sci_tx_empty, sci_tx_done, sci_rx_idle;
    logic sci_rx_ie, sci_tx_empty_ie, sci_tx_done_ie, sci_idle_ie, sci_rx_on, sci_tx_on;
    logic [15:0] vec_addr;
    logic vec_valid, wake;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    irq_vector_resolver u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic quiet();
        mask_x = 1'b0; mask_i = 1'b0; nmi_n = 1'b1; irq_n = 1'b1;
        trap_illegal = 1'b0; trap_swi = 1'b0; boundary_stb = 1'b0;
        tmr_flag = '0; tmr_en = '0; spi_flag = 0; spi_fault = 0; spi_en = 0;
        sci_rx_full = 0; sci_rx_overrun = 0; sci_tx_empty = 0; sci_tx_done = 0;
        sci_rx_idle = 0; sci_rx_ie = 0; sci_tx_empty_ie = 0; sci_tx_done_ie = 0;
        sci_idle_ie = 0; sci_rx_on = 0; sci_tx_on = 0;
    endtask

    // Pulse the boundary strobe for one edge; outputs are sampled one negedge later.
    task automatic boundary();
        boundary_stb = 1'b1;
        @(negedge clk);
        boundary_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        quiet();
        repeat (3) @(negedge clk);
        chk("R1 addr", vec_addr, 16'hFFF2);
        chk("R1 valid", vec_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_hold();
        quiet(); nmi_n = 0;
        boundary();
        chk("R3 nmi", vec_addr, 16'hFFF4);
        nmi_n = 1; irq_n = 0; tmr_flag[0] = 1; tmr_en[0] = 1;
        repeat (3) @(negedge clk);
        chk("R2 hold addr", vec_addr, 16'hFFF4);
        chk("R2 hold valid", vec_valid, 1'b1);
        boundary();
        chk("R2 load", vec_addr, 16'hFFF2);
    endtask

    task automatic t_nmi();
        quiet(); nmi_n = 0; irq_n = 0; mask_i = 1; trap_illegal = 1;
        boundary();
        chk("R3 outranks traps, ignores mask_i", vec_addr, 16'hFFF4);
        mask_x = 1; mask_i = 0;
        boundary();
        chk("R3 mask_x blocks nmi", vec_addr, 16'hFFF2);
        chk("R11 wake irq only", wake, 1'b1);
    endtask

    task automatic t_walk();
        quiet();
        irq_n = 0; tmr_flag = '1; tmr_en = '1; spi_flag = 1; spi_en = 1;
        sci_tx_empty = 1; sci_tx_empty_ie = 1; sci_tx_on = 1;
        for (int k = 0; k < 15; k++) begin
            boundary();
            chk($sformatf("R4 rank %0d", k), vec_addr, 16'hFFF2 - 16'(2 * k));
            chk($sformatf("R4 valid %0d", k), vec_valid, 1'b1);
            if (k == 0) irq_n = 1;
            else if (k <= 12) tmr_en[k-1] = 0;   // R5: flag stays set, enable removed
            else if (k == 13) spi_en = 0;
            else sci_tx_on = 0;
        end
        boundary();
        chk("R10 empty valid", vec_valid, 1'b0);
        chk("R10 empty addr", vec_addr, 16'hFFF2);
        chk("R5 flags without enables wake", wake, 1'b0);
        tmr_flag = '0; tmr_en[5] = 1;
        boundary();
        chk("R5 enable alone", vec_valid, 1'b0);
    endtask

    task automatic t_spi();
        quiet(); spi_fault = 1; spi_en = 1;
        boundary();
        chk("R6 fault path", vec_addr, 16'hFFD8);
        spi_en = 0;
        boundary();
        chk("R6 disabled", vec_valid, 1'b0);
    endtask

    task automatic t_sci();
        quiet(); sci_rx_overrun = 1; sci_rx_ie = 1; sci_rx_on = 1;
        boundary(); chk("R7 overrun", vec_addr, 16'hFFD6);
        sci_rx_on = 0;
        boundary(); chk("R7 rx off", vec_valid, 1'b0);
        quiet(); sci_rx_full = 1; sci_rx_ie = 1; sci_rx_on = 1;
        boundary(); chk("R7 rx full", vec_addr, 16'hFFD6);
        quiet(); sci_tx_done = 1; sci_tx_done_ie = 1; sci_tx_on = 1;
        boundary(); chk("R7 tx done", vec_addr, 16'hFFD6);
        sci_tx_done_ie = 0; sci_tx_empty_ie = 1;
        boundary(); chk("R7 tx done no ie", vec_valid, 1'b0);
        quiet(); sci_rx_idle = 1; sci_idle_ie = 1; sci_tx_on = 1;
        boundary(); chk("R7 idle needs rx_on", vec_valid, 1'b0);
        sci_rx_on = 1;
        boundary(); chk("R7 idle", vec_addr, 16'hFFD6);
    endtask

    task automatic t_mask_i();
        quiet(); mask_i = 1; irq_n = 0; tmr_flag[3] = 1; tmr_en[3] = 1;
        boundary();
        chk("R8 masked valid", vec_valid, 1'b0);
        chk("R11 masked wake", wake, 1'b0);
    endtask

    task automatic t_traps();
        quiet(); mask_i = 1; mask_x = 1; nmi_n = 0; trap_swi = 1;
        boundary(); chk("R9 swi under masks", vec_addr, 16'hFFF6);
        trap_illegal = 1;
        boundary(); chk("R9 illegal over swi", vec_addr, 16'hFFF8);
        chk("R11 traps no wake", wake, 1'b0);
        mask_i = 0; tmr_flag[11] = 1; tmr_en[11] = 1;
        boundary(); chk("R9 interrupt over trap", vec_addr, 16'hFFDA);
    endtask

    task automatic t_irq_level();
        quiet(); irq_n = 0;
        boundary(); chk("R12 first", vec_addr, 16'hFFF2);
        chk("R12 first valid", vec_valid, 1'b1);
        boundary(); chk("R12 repeat", vec_valid, 1'b1);
        boundary(); chk("R12 repeat addr", vec_addr, 16'hFFF2);
        irq_n = 1;
        boundary(); chk("R12 released", vec_valid, 1'b0);
    endtask

    initial begin
        t_reset();
        t_hold();
        t_nmi();
        t_walk();
        t_spi();
        t_sci();
        t_mask_i();
        t_traps();
        t_irq_level();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule